// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a processor core and decides which interrupt the core should run next. It watches thirteen peripheral request lines and three fixed system exceptions (reset, non-maskable interrupt and hard fault). Each peripheral line has a pending flag, an enable flag and a two-bit programmable level. Each cycle a combinational arbiter picks the highest-precedence request that is pending and allowed to fire. Lower numbers win. A tie between two lines at the same level goes to the lower line number. The system exceptions rank above every programmable level.

A request is offered to the core only when it outranks the handler that is now running. The priority of that handler is the top of a five-entry stack. The stack is pushed when the core takes a vector and popped when the core signals a return from a handler.

Software sets the enables and levels through a small word-wide register port. The enable words are write-one-to-set and write-one-to-clear. A three-state handshake machine handles the core side:

| State | Meaning |
|-------|---------|
| IDLE | Nothing is offered. |
| OFFER | A vector is offered to the core. |
| ACK | The take is confirmed for one cycle. |

| Transition | Condition |
|------------|-----------|
| IDLE to OFFER | A winner beats the running priority and the stack has room. |
| OFFER to OFFER | The winner still qualifies and is not taken; the vector is refreshed. |
| OFFER to ACK | The core takes the vector. |
| OFFER to IDLE | The winner no longer qualifies. |
| ACK to IDLE | Always, after one cycle. |

Top module: `vect_intc`

## Requirements
- R1: After reset, all enables and levels read 0, the stack is empty and the reset exception is pending. `req_o` rises with vector 1 on the first clock edge after reset is released.
- R2: A line's pending flag is set on a rising edge of its request input and cleared when its vector is taken. A pending line that is disabled is never offered. The line is offered once it is enabled.
- R3: A write to address 0 sets every enable bit where the data bit is 1. A write to address 1 clears those bits. Zero data bits leave enables unchanged. Both addresses read back the enable mask in bits [12:0].
- R4: Address 4+k holds the levels of lines 4k to 4k+3, one byte each, with line 4k in bits [7:0]. Only bits [7:6] of each byte are stored, so a byte reads 0x00, 0x40, 0x80 or 0xC0. Bytes for lines that do not exist read 0.
- R5: Among pending enabled lines, the lowest level value wins.
- R6: When lines tie on level, the lower line number wins.
- R7: Vectors are 1 for reset, 2 for the NMI and 3 for hard fault, with that order of precedence above all lines. Line n uses vector 16+n.
- R8: A rising edge of the OR of the software and hardware NMI inputs makes the NMI pending. No enable affects it.
- R9: A request is offered only if its precedence is strictly higher than that of the running handler. An equal request waits until a return.
- R10: The active-priority stack holds 5 entries. While it is full nothing is offered. A return with the stack empty is ignored.
- R11: When `take_i` is high while `req_o` is high, `ack_o` is high for exactly the next cycle. `req_o` is low during that cycle and `vec_o` still shows the taken vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 13 | Peripheral request lines, edge-detected |
| nmi_sw_i | input | 1 | Software NMI trigger |
| nmi_hw_i | input | 1 | Hardware error NMI source |
| hfault_i | input | 1 | Hard fault request, edge-detected |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| req_o | output | 1 | A vector is offered for preemption |
| vec_o | output | 5 | Offered or acknowledged vector number |
| take_i | input | 1 | Core takes the offered vector |
| ack_o | output | 1 | One-cycle confirmation of a take |
| ret_i | input | 1 | Core returns from the current handler |

## Verification
The bench presents equal-priority requests during a running handler. A controller that preempted on equal precedence, or that broke ties toward the higher line, would offer the wrong vector first. It nests five handlers to fill the stack and then raises an NMI. A design that ignored the full condition would offer it at once, and a design that lost the count would never offer it after the return. It also writes zero data to the enable words, writes all ones to a level word, and leaves a line pending while disabled. These show whether zeros disturb the enables, whether low level bits leak through, and whether enable gates the offer rather than the pending flag.

// File: rtl/vect_intc_pkg.sv
package vect_intc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OFFER,
        ST_ACK
    } ctl_state_e;

    // system exceptions: index doubles as rank, vector is index + 1
    localparam int SYS_EXC       = 3;
    localparam int SYS_RESET     = 0;
    localparam int SYS_NMI       = 1;
    localparam int SYS_HFAULT    = 2;
    localparam int VEC_RESET     = 1;
    localparam int VEC_LINE_BASE = 16;
    localparam int FIELD_W       = 8;

endpackage

// File: rtl/vect_intc_regs.sv
module vect_intc_regs
    import vect_intc_pkg::*;
#(
    parameter int NUM_LINES = 13,
    parameter int PRIO_BITS = 2,
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 32,
    parameter int PRIO_BASE = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              rdata,
    output logic [NUM_LINES-1:0]           en_mask,
    output logic [NUM_LINES*PRIO_BITS-1:0] prio_flat
);

    localparam int FIELDS = DATA_W / FIELD_W;
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(1);

    logic [PRIO_BITS-1:0] prio_q [NUM_LINES];

    function automatic logic [ADDR_W-1:0] line_addr(input int line);
        return ADDR_W'(PRIO_BASE + line / FIELDS);
    endfunction

    function automatic int field_msb(input int line);
        return (line % FIELDS) * FIELD_W + FIELD_W - 1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_mask <= '0;
        end else if (wr_en) begin
            if (addr == A_SET) begin
                en_mask <= en_mask | wdata[NUM_LINES-1:0];
            end else if (addr == A_CLR) begin
                en_mask <= en_mask & ~wdata[NUM_LINES-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                prio_q[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (addr == line_addr(i)) begin
                    prio_q[i] <= wdata[field_msb(i) -: PRIO_BITS];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_SET || addr == A_CLR) begin
            rdata[NUM_LINES-1:0] = en_mask;
        end
        for (int i = 0; i < NUM_LINES; i++) begin
            if (addr == line_addr(i)) begin
                rdata[field_msb(i) -: PRIO_BITS] = prio_q[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_flat
        assign prio_flat[g*PRIO_BITS +: PRIO_BITS] = prio_q[g];
    end

    // R3: zero data bits leave the enable mask untouched
    assert_zero_write_keeps_enable_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == A_SET || addr == A_CLR) && wdata[NUM_LINES-1:0] == '0)
        |=> $stable(en_mask));

    // R3: every bit written with 1 to the set word is enabled afterwards
    assert_set_enables_bits_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_SET)
        |=> ((en_mask & $past(wdata[NUM_LINES-1:0])) == $past(wdata[NUM_LINES-1:0])));

endmodule

// File: rtl/vect_intc_arb.sv
module vect_intc_arb
    import vect_intc_pkg::*;
#(
    parameter int NUM_LINES = 13,
    parameter int PRIO_BITS = 2,
    parameter int RANK_W    = 3,
    parameter int VEC_W     = 5,
    parameter int IDLE_RANK = 7
) (
    input  logic [SYS_EXC-1:0]             sys_pend,
    input  logic [NUM_LINES-1:0]           line_pend,
    input  logic [NUM_LINES-1:0]           en_mask,
    input  logic [NUM_LINES*PRIO_BITS-1:0] prio_flat,
    output logic                           win_valid,
    output logic [VEC_W-1:0]               win_vec,
    output logic [RANK_W-1:0]              win_rank
);

    logic [RANK_W-1:0] cand;

    always_comb begin
        win_valid = 1'b0;
        win_rank  = RANK_W'(IDLE_RANK);
        win_vec   = '0;
        cand      = '0;
        // strict compare keeps the lower line on a tie
        for (int i = 0; i < NUM_LINES; i++) begin
            cand = RANK_W'(SYS_EXC) + RANK_W'(prio_flat[i*PRIO_BITS +: PRIO_BITS]);
            if (line_pend[i] && en_mask[i] && cand < win_rank) begin
                win_valid = 1'b1;
                win_rank  = cand;
                win_vec   = VEC_W'(VEC_LINE_BASE + i);
            end
        end
        // system exceptions override, most urgent last
        for (int s = SYS_EXC - 1; s >= 0; s--) begin
            if (sys_pend[s]) begin
                win_valid = 1'b1;
                win_rank  = RANK_W'(s);
                win_vec   = VEC_W'(VEC_RESET + s);
            end
        end
    end

endmodule

// File: rtl/vect_intc_stack.sv
module vect_intc_stack #(
    parameter int DEPTH     = 5,
    parameter int RANK_W    = 3,
    parameter int IDLE_RANK = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [RANK_W-1:0] push_rank,
    input  logic              pop,
    output logic [RANK_W-1:0] active_rank,
    output logic              full
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [RANK_W-1:0] slot_q [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic              do_push;
    logic              do_pop;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (do_push && !do_pop) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else if (do_pop && !do_push) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && do_pop) begin
            slot_q[cnt_q - CNT_W'(1)] <= push_rank;
        end else if (do_push) begin
            slot_q[cnt_q] <= push_rank;
        end
    end

    assign active_rank = (cnt_q == '0) ? RANK_W'(IDLE_RANK) : slot_q[cnt_q - CNT_W'(1)];

    // R10: the controller never takes a vector into a full stack
    assert_push_has_room_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R9: a taken vector always outranks the running handler
    assert_push_outranks_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        push |-> (push_rank < active_rank));

    // R10: a return on an empty stack leaves it empty
    assert_empty_pop_holds_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        (pop && !push && cnt_q == '0) |=> (active_rank == RANK_W'(IDLE_RANK)));

endmodule

// File: rtl/vect_intc.sv
module vect_intc
    import vect_intc_pkg::*;
#(
    parameter int NUM_LINES   = 13,
    parameter int PRIO_BITS   = 2,
    parameter int STACK_DEPTH = 5,
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 32,
    localparam int VEC_W      = $clog2(VEC_LINE_BASE + NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_i,
    input  logic                 nmi_sw_i,
    input  logic                 nmi_hw_i,
    input  logic                 hfault_i,
    input  logic                 reg_wr_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [DATA_W-1:0]    reg_wdata_i,
    output logic [DATA_W-1:0]    reg_rdata_o,
    output logic                 req_o,
    output logic [VEC_W-1:0]     vec_o,
    input  logic                 take_i,
    output logic                 ack_o,
    input  logic                 ret_i
);

    localparam int IDLE_RANK = SYS_EXC + (1 << PRIO_BITS);
    localparam int RANK_W    = $clog2(IDLE_RANK + 1);

    logic [NUM_LINES-1:0]           en_mask;
    logic [NUM_LINES*PRIO_BITS-1:0] prio_flat;
    logic [NUM_LINES-1:0]           irq_q, line_pend, line_set, line_clr;
    logic [SYS_EXC-1:0]             sys_pend, sys_set, sys_clr;
    logic                           nmi_q, hf_q, nmi_src;
    logic                           win_valid, stack_full, preempt, take_fire;
    logic [VEC_W-1:0]               win_vec, vec_q;
    logic [RANK_W-1:0]              win_rank, rank_q, active_rank;
    ctl_state_e                     state_q, nxt;

    vect_intc_regs #(
        .NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRIO_BASE(4)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_i), .addr(reg_addr_i),
        .wdata(reg_wdata_i), .rdata(reg_rdata_o),
        .en_mask(en_mask), .prio_flat(prio_flat)
    );

    vect_intc_arb #(
        .NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS), .RANK_W(RANK_W),
        .VEC_W(VEC_W), .IDLE_RANK(IDLE_RANK)
    ) u_arb (
        .sys_pend(sys_pend), .line_pend(line_pend), .en_mask(en_mask),
        .prio_flat(prio_flat), .win_valid(win_valid),
        .win_vec(win_vec), .win_rank(win_rank)
    );

    vect_intc_stack #(
        .DEPTH(STACK_DEPTH), .RANK_W(RANK_W), .IDLE_RANK(IDLE_RANK)
    ) u_stack (
        .clk(clk), .rst_n(rst_n), .push(take_fire), .push_rank(rank_q),
        .pop(ret_i), .active_rank(active_rank), .full(stack_full)
    );

    // ---------------- request capture ----------------
    assign nmi_src   = nmi_sw_i | nmi_hw_i;
    assign line_set  = irq_i & ~irq_q;
    assign sys_set   = {hfault_i & ~hf_q, nmi_src & ~nmi_q, 1'b0};
    assign take_fire = (state_q == ST_OFFER) && take_i;

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            line_clr[i] = take_fire && (vec_q == VEC_W'(VEC_LINE_BASE + i));
        end
        for (int s = 0; s < SYS_EXC; s++) begin
            sys_clr[s] = take_fire && (vec_q == VEC_W'(VEC_RESET + s));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q     <= '0;
            nmi_q     <= 1'b0;
            hf_q      <= 1'b0;
            line_pend <= '0;
            sys_pend  <= SYS_EXC'(1) << SYS_RESET;
        end else begin
            irq_q     <= irq_i;
            nmi_q     <= nmi_src;
            hf_q      <= hfault_i;
            line_pend <= (line_pend & ~line_clr) | line_set;
            sys_pend  <= (sys_pend & ~sys_clr) | sys_set;
        end
    end

    assign preempt = win_valid && (win_rank < active_rank) && !stack_full;

    // ---------------- handshake state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= nxt;
        end
    end

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_IDLE:  if (preempt) nxt = ST_OFFER;
            ST_OFFER: begin
                if (take_i)        nxt = ST_ACK;
                else if (!preempt) nxt = ST_IDLE;
            end
            ST_ACK:   nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q  <= '0;
            rank_q <= RANK_W'(IDLE_RANK);
        end else if (nxt == ST_OFFER) begin
            vec_q  <= win_vec;
            rank_q <= win_rank;
        end
    end

    assign req_o = (state_q == ST_OFFER);
    assign ack_o = (state_q == ST_ACK);
    assign vec_o = vec_q;

    // R9: an offered vector strictly outranks the running handler
    assert_offer_outranks_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        req_o |-> (rank_q < active_rank));

    // R11: a take is confirmed in the next cycle with the offer withdrawn
    assert_take_acks_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        (req_o && take_i) |=> (ack_o && !req_o && $stable(vec_o)));

    // R11: the confirmation lasts one cycle
    assert_ack_single_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

endmodule

// File: tb/vect_intc_bench.sv
module vect_intc_bench;

    localparam int N = 13;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [N-1:0] irq_i;
    logic        nmi_sw_i, nmi_hw_i, hfault_i;
    logic        reg_wr_i;
    logic [2:0]  reg_addr_i;
    logic [31:0] reg_wdata_i;
    logic [31:0] reg_rdata_o;
    logic        req_o, ack_o, take_i, ret_i;
    logic [4:0]  vec_o;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    bit done = 0;

    always #5 clk = ~clk;

    vect_intc u_vect_intc (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .nmi_sw_i(nmi_sw_i),
        .nmi_hw_i(nmi_hw_i), .hfault_i(hfault_i), .reg_wr_i(reg_wr_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .req_o(req_o), .vec_o(vec_o),
        .take_i(take_i), .ack_o(ack_o), .ret_i(ret_i)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
        step();
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
        reg_addr_i = a;
        #1;
        chk(req, reg_rdata_o, exp);
    endtask

    task automatic pulse_irq(input logic [N-1:0] m);
        irq_i = m; step(); irq_i = '0;
    endtask

    task automatic pulse_hf();
        hfault_i = 1'b1; step(); hfault_i = 1'b0;
    endtask

    // driver side of the scoreboard: check the offer, queue it, take it
    task automatic serve(input int v, input string req);
        chk({req, " req_o"}, req_o, 1);
        chk({req, " vec_o"}, vec_o, v);
        exp_q.push_back(v);
        take_i = 1'b1;
        step();
        take_i = 1'b0;
        chk("R11 req_o low during ack", req_o, 0);
    endtask

    task automatic ret();
        ret_i = 1'b1; step(); ret_i = 1'b0;
    endtask

    task automatic quiet(input int n, input string req);
        repeat (n) begin
            step();
            chk({req, " no offer"}, req_o, 0);
        end
    endtask

    // monitor side of the scoreboard: every ack must match a queued take
    always @(negedge clk) begin
        if (rst_n === 1'b1 && ack_o === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk("R11 unexpected ack", 1, 0);
            end else begin
                int v;
                v = exp_q.pop_front();
                chk("R11 ack vector", vec_o, v);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; irq_i = '0; nmi_sw_i = 0; nmi_hw_i = 0; hfault_i = 0;
        reg_wr_i = 0; reg_addr_i = '0; reg_wdata_i = '0; take_i = 0; ret_i = 0;
        step(3);
        // R1 reset state
        chk("R1 req_o in reset", req_o, 0);
        chk("R1 ack_o in reset", ack_o, 0);
        rd(3'd0, 32'h0, "R1 enables");
        rd(3'd4, 32'h0, "R1 levels");
        rst_n = 1'b1;
        step();
        serve(1, "R1 R7 reset vector");
        // R9: NMI cannot preempt the reset handler; R8 sw source, no enable
        nmi_sw_i = 1'b1; step(); nmi_sw_i = 1'b0;
        quiet(3, "R9 NMI under reset");
        ret(); step();
        serve(2, "R8 software NMI");
        ret();

        // R3 enable words
        wr(3'd0, 32'h5);      rd(3'd0, 32'h5, "R3 set");
        wr(3'd0, 32'h0);      rd(3'd0, 32'h5, "R3 set zero");
        wr(3'd1, 32'h1);      rd(3'd1, 32'h4, "R3 clear");
        wr(3'd1, 32'h0);      rd(3'd1, 32'h4, "R3 clear zero");
        wr(3'd1, 32'h4);      rd(3'd0, 32'h0, "R3 clear all");
        // R4 level fields
        wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, 32'hC0C0_C0C0, "R4 top bits only");
        wr(3'd7, 32'hFFFF_FFFF); rd(3'd7, 32'h0000_00C0, "R4 absent lines");
        wr(3'd4, 32'h0); wr(3'd7, 32'h0);

        // R5: line 2 at 128, line 5 at 64
        wr(3'd4, 32'h0080_0000);
        wr(3'd5, 32'h0000_4000);
        wr(3'd0, 32'h24);
        pulse_irq(13'h24); step();
        serve(21, "R5 lower level wins");
        quiet(3, "R9 lower precedence waits");
        ret(); step();
        serve(18, "R5 second");
        ret();

        // R2: disabled pending line
        pulse_irq(13'h1);
        quiet(3, "R2 disabled");
        wr(3'd0, 32'h1); step();
        serve(16, "R2 enabled later");
        ret();

        // R6 ties, R9 equal, R7 hard fault
        wr(3'd5, 32'h0);
        wr(3'd0, 32'h88);
        pulse_irq(13'h88); step();
        serve(19, "R6 lower line on tie");
        quiet(2, "R9 equal level");
        pulse_hf(); step();
        serve(3, "R7 hard fault above lines");
        ret();
        quiet(2, "R9 equal after return");
        ret(); step();
        serve(23, "R6 tied line later");
        ret();

        // R10 stack depth
        wr(3'd6, 32'h0040_80C0);
        wr(3'd0, 32'hF00);
        for (int i = 8; i < 12; i++) begin
            pulse_irq(13'(1) << i); step();
            serve(16 + i, "R10 nesting");
        end
        pulse_hf(); step();
        serve(3, "R10 fifth level");
        nmi_hw_i = 1'b1; step(); nmi_hw_i = 1'b0;
        quiet(3, "R10 full stack");
        ret(); step();
        serve(2, "R8 R10 hardware NMI after pop");
        for (int i = 0; i < 6; i++) ret();
        ret();
        pulse_irq(13'h100); step();
        serve(24, "R10 empty return ignored");
        ret();
        quiet(2, "R2 idle at end");

        step(2);
        chk("R11 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule